// File: doc/BRIEF.md
# OSD Character Cell Timing Counter

This block produces the position counters that an on-screen display overlay needs to know which character cell and which glyph scan line the dot clock is in. It runs on the dot clock. A one-cycle line-start strobe marks the start of each display line, and a one-cycle frame-start strobe marks the first line of each frame. The outputs are the character column, the dot inside the current character, the character row, the scan line inside that row, and a flag that is high while the current dot is inside a glyph.

Each line is cut into cells twelve dots wide, up to a programmed number of characters. Past the last character the column holds and the flag stays low for the rest of the line. Vertically, each character row has a fixed number of glyph lines, set by a parameter that defaults to 18. A programmed number of blank spacer lines, from 0 to 31, follows those glyph lines. Both settings are taken from their inputs only on a frame-start strobe, so the layout stays fixed for the whole frame. Sync generation, font lookup and pixel mixing happen elsewhere.

Top module: `osd_cell_timer`

## Requirements
- R1: After reset the character count is 40 and the spacer count is 0, and all counters are 0. `glyph_active` stays low until the first `frame_start`.
- R2: While the column is below the character count, `dot_idx` advances by one per clock from 0 to 11. When it wraps from 11 to 0, `col_idx` increments.
- R3: In the cycle after a `line_start` edge, `col_idx` and `dot_idx` are both 0.
- R4: Once `col_idx` reaches the character count, it holds there with `dot_idx` at 0 and `glyph_active` low until the next `line_start`.
- R5: A `cfg_chars` value below 36 that is sampled at frame start is used as 36. Values from 36 to 127 are used as given.
- R6: Each `line_start` without `frame_start` advances `row_line`. After the last line of a row (glyph height plus spacer count, minus one), `row_line` returns to 0 and `row_idx` increments, wrapping at its width.
- R7: While `row_line` is at or above the glyph height (a spacer line), `glyph_active` is low and `row_idx` is unchanged.
- R8: A `frame_start` clears `row_idx` and `row_line` and samples `cfg_chars` and `cfg_space`. Changes on those inputs at any other time have no effect on the counters.
- R9: With a spacer count of 0, a row is exactly the glyph height in lines, with no spacer lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle strobe at the start of a line |
| frame_start | input | 1 | One-cycle strobe at the start of a frame |
| cfg_chars | input | 7 | Characters per line, floor 36 |
| cfg_space | input | 5 | Spacer lines after each character row |
| col_idx | output | 7 | Character column index |
| dot_idx | output | 4 | Dot within the character, 0 to 11 |
| row_idx | output | 5 | Character row index |
| row_line | output | 6 | Scan line within the character row |
| glyph_active | output | 1 | High while inside a glyph cell |

## Verification
The hardest states to reach from the ports are the row-wrap boundary with a large spacer count and a saturated column at the widest setting of 127 characters. Reaching them takes many line strobes, or more than 1500 dot clocks in one line. Directed frames do this: one uses 31 spacers with many short lines, and full-length lines are run at 36, 40 and 127 characters. Random frames then vary the settings, line lengths and line counts. They also change the configuration inputs in the middle of a frame to show that those changes are ignored.

// File: rtl/osd_cell_timer.sv
module osd_cell_timer #(
  parameter int DOTS      = 12,
  parameter int GLYPH_H   = 18,
  parameter int CHAR_W    = 7,
  parameter int SPACE_W   = 5,
  parameter int ROW_W     = 5,
  parameter int MIN_CHARS = 36,
  parameter int RST_CHARS = 40,
  localparam int DOT_W    = $clog2(DOTS),
  localparam int LINE_W   = $clog2(GLYPH_H + 2**SPACE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              frame_start,
  input  logic [CHAR_W-1:0] cfg_chars,
  input  logic [SPACE_W-1:0] cfg_space,
  output logic [CHAR_W-1:0] col_idx,
  output logic [DOT_W-1:0]  dot_idx,
  output logic [ROW_W-1:0]  row_idx,
  output logic [LINE_W-1:0] row_line,
  output logic              glyph_active
);

  logic [CHAR_W-1:0]  chars_q;
  logic [SPACE_W-1:0] space_q;
  logic               armed_q;
  logic [CHAR_W-1:0]  chars_in;
  logic               h_run;
  logic [LINE_W-1:0]  last_line;

  assign chars_in  = (cfg_chars < CHAR_W'(MIN_CHARS)) ? CHAR_W'(MIN_CHARS) : cfg_chars;
  assign h_run     = col_idx < chars_q;
  assign last_line = LINE_W'(GLYPH_H - 1) + LINE_W'(space_q);
  assign glyph_active = armed_q && h_run && (row_line < LINE_W'(GLYPH_H));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chars_q <= CHAR_W'(RST_CHARS);
      space_q <= '0;
      armed_q <= 1'b0;
    end else if (frame_start) begin
      chars_q <= chars_in;
      space_q <= cfg_space;
      armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_idx <= '0;
      dot_idx <= '0;
    end else if (line_start) begin
      col_idx <= '0;
      dot_idx <= '0;
    end else if (h_run) begin
      if (dot_idx == DOT_W'(DOTS - 1)) begin
        dot_idx <= '0;
        col_idx <= col_idx + 1'b1;
      end else begin
        dot_idx <= dot_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_idx  <= '0;
      row_line <= '0;
    end else if (frame_start) begin
      row_idx  <= '0;
      row_line <= '0;
    end else if (line_start) begin
      if (row_line >= last_line) begin
        row_line <= '0;
        row_idx  <= row_idx + 1'b1;
      end else begin
        row_line <= row_line + 1'b1;
      end
    end
  end

endmodule

// File: rtl/osd_cell_timer_chk.sv
module osd_cell_timer_chk #(
  parameter int DOTS    = 12,
  parameter int GLYPH_H = 18,
  parameter int CHAR_W  = 7,
  parameter int SPACE_W = 5,
  parameter int DOT_W   = 4,
  parameter int ROW_W   = 5,
  parameter int LINE_W  = 6,
  parameter int MIN_CHARS = 36
) (
  input logic               clk,
  input logic               rst_n,
  input logic               line_start,
  input logic               frame_start,
  input logic [CHAR_W-1:0]  col_idx,
  input logic [DOT_W-1:0]   dot_idx,
  input logic [ROW_W-1:0]   row_idx,
  input logic [LINE_W-1:0]  row_line,
  input logic               glyph_active,
  input logic [CHAR_W-1:0]  chars_q,
  input logic [SPACE_W-1:0] space_q
);

  AST_DOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dot_idx <= DOT_W'(DOTS - 1)); // R2

  AST_DOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && col_idx < chars_q && dot_idx == DOT_W'(DOTS - 1))
    |=> (dot_idx == 0 && col_idx == $past(col_idx) + 1'b1)); // R2

  AST_LINE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (col_idx == 0 && dot_idx == 0)); // R3

  AST_TAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (col_idx >= chars_q) |-> !glyph_active); // R4

  AST_CHAR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    chars_q >= CHAR_W'(MIN_CHARS)); // R5

  AST_VERT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && !frame_start) |=> ($stable(row_idx) && $stable(row_line))); // R6

  AST_SPACER_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (row_line >= LINE_W'(GLYPH_H)) |-> !glyph_active); // R7

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(chars_q) && $stable(space_q))); // R8

  AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (row_idx == 0 && row_line == 0)); // R8

endmodule

bind osd_cell_timer osd_cell_timer_chk #(
  .DOTS(DOTS), .GLYPH_H(GLYPH_H), .CHAR_W(CHAR_W), .SPACE_W(SPACE_W),
  .DOT_W(DOT_W), .ROW_W(ROW_W), .LINE_W(LINE_W), .MIN_CHARS(MIN_CHARS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .frame_start(frame_start),
  .col_idx(col_idx), .dot_idx(dot_idx), .row_idx(row_idx), .row_line(row_line),
  .glyph_active(glyph_active), .chars_q(chars_q), .space_q(space_q)
);

// File: tb/osd_cell_timer_test.sv
module osd_cell_timer_test;
  localparam int G = 18;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_start = 1'b0;
  logic       frame_start = 1'b0;
  logic [6:0] cfg_chars = 7'd0;
  logic [4:0] cfg_space = 5'd0;
  logic [6:0] col_idx;
  logic [3:0] dot_idx;
  logic [4:0] row_idx;
  logic [5:0] row_line;
  logic       glyph_active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int cyc = 0;

  int e_chars = 40;
  int e_space = 0;
  int n_line = 0;
  bit armed = 1'b0;
  bit floored = 1'b0;

  always #4 clk = ~clk;

  osd_cell_timer uut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .frame_start(frame_start),
    .cfg_chars(cfg_chars), .cfg_space(cfg_space), .col_idx(col_idx),
    .dot_idx(dot_idx), .row_idx(row_idx), .row_line(row_line),
    .glyph_active(glyph_active)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_col(int k);
    return (k / 12 < e_chars) ? k / 12 : e_chars;
  endfunction

  function automatic int exp_dot(int k);
    return (k / 12 < e_chars) ? k % 12 : 0;
  endfunction

  task automatic check_cycle(int k, bit fs);
    int ec = exp_col(k);
    int rl = G + e_space;
    int el = n_line % rl;
    int er = (n_line / rl) % 32;
    int ea = (armed && ec < e_chars && el < G) ? 1 : 0;
    string th, tv, ta;
    th = (k == 0) ? "R3" : (ec == e_chars) ? (floored ? "R5" : "R4") : "R2";
    tv = fs ? "R8" : (el >= G) ? "R7" : (e_space == 0) ? "R9" : "R6";
    ta = !armed ? "R1" : (el >= G) ? "R7" : (ec == e_chars) ? "R4" : "R2";
    chk(th, "col", int'(col_idx), ec);
    chk(th, "dot", int'(dot_idx), exp_dot(k));
    chk(tv, "row", int'(row_idx), er);
    chk(tv, "line", int'(row_line), el);
    chk(ta, "active", int'(glyph_active), ea);
  endtask

  task automatic run_line(bit fs, int len, int cc, int cs, bit poke);
    @(negedge clk);
    line_start = 1'b1;
    frame_start = fs;
    if (fs) begin
      cfg_chars = 7'(cc);
      cfg_space = 5'(cs);
    end
    @(posedge clk);
    if (fs) begin
      e_chars = (cc < 36) ? 36 : cc;
      floored = (cc < 36);
      e_space = cs;
      n_line = 0;
      armed = 1'b1;
    end else begin
      n_line++;
    end
    @(negedge clk);
    line_start = 1'b0;
    frame_start = 1'b0;
    check_cycle(0, fs);
    for (int k = 1; k < len; k++) begin
      @(negedge clk);
      if (poke && k == len / 2) begin
        cfg_chars = 7'($urandom_range(0, 127));
        cfg_space = 5'($urandom_range(0, 31));
      end
      check_cycle(k, 1'b0);
    end
  endtask

  task automatic run_frame(int cc, int cs, int lines, int lmin, int lmax, bit poke);
    run_line(1'b1, $urandom_range(lmin, lmax), cc, cs, 1'b0);
    for (int i = 1; i < lines; i++)
      run_line(1'b0, $urandom_range(lmin, lmax), 0, 0, poke);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    #3;
    // R1: reset state
    chk("R1", "col", int'(col_idx), 0);
    chk("R1", "dot", int'(dot_idx), 0);
    chk("R1", "row", int'(row_idx), 0);
    chk("R1", "line", int'(row_line), 0);
    chk("R1", "active", int'(glyph_active), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: before any frame strobe, default 40 chars, flag low
    run_line(1'b0, 40 * 12 + 6, 0, 0, 1'b0);
    run_line(1'b0, 30, 0, 0, 1'b0);
    // R5: floor, full lines
    run_frame(10, 0, 3, 36 * 12 + 5, 36 * 12 + 8, 1'b0);
    run_frame(0, 2, 2, 440, 445, 1'b0);
    // R4: widest setting, saturation
    run_frame(127, 1, 2, 127 * 12 + 4, 127 * 12 + 6, 1'b0);
    // R9: no spacers, row wrap at glyph height
    run_frame(36, 0, 40, 15, 25, 1'b1);
    // R7: maximum spacers, several rows
    run_frame(50, 31, 110, 8, 14, 1'b1);
    // R8: config pokes mid-frame ignored, random frames
    for (int f = 0; f < 12; f++)
      run_frame($urandom_range(0, 127), $urandom_range(0, 31),
                $urandom_range(5, 60), 1, 500, 1'b1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule